// File: doc/BRIEF.md
# Byte ALU with Status Flag Generation

This block is the single-cycle arithmetic and logic unit of a small 8-bit processor datapath. Each cycle it takes two byte operands, an operation code, and the carry and zero flags currently held in the status register. The second operand may come from a register or from an immediate field; the block does not care which. It returns the byte result, a six-bit vector of new flag values, and a six-bit write mask. The status register should take only the flag bits whose mask bit is set. Every other flag keeps its old value.

The block is purely combinational. Additions and subtractions, including compare, negate, increment and decrement, all share one adder. The left shift and left rotate also use that adder, by adding the operand to itself. Bitwise operations and right-side data movement sit in two small separate units. A final selector picks the result, the flags and the write mask from the operation code.

Top module: `byte_alu`

## Requirements
- R1: `op_i` encodes ADD=0, ADDC=1, SUB=2, SUBC=3, CMP=4, CMPC=5, NEG=6, INC=7, DEC=8, AND=9, OR=10, XOR=11, CLRB=12, COM=13, SHL=14, SHR=15, RLC=16, RRC=17, SAR=18, SWAP=19, SETALL=20. Flag vector and mask bits are C=0, Z=1, N=2, V=3, S=4, H=5. Codes 21 to 31 produce result 0 and mask 0.
- R2: ADD gives a+b and ADDC gives a+b+c_i. Both write all six flags: C is carry out of bit 7, H is carry out of bit 3, V is signed overflow, N is result bit 7, and Z is set when the result is zero.
- R3: SUB and CMP give a-b. SUBC and CMPC give a-b-c_i. All four write all six flags, with C set on borrow out of bit 7 and H set on borrow out of bit 3.
- R4: For SUBC and CMPC, Z is 1 only if the result is zero and z_i is 1.
- R5: NEG gives 0-a with all six flags, computed as the subtraction 0-a.
- R6: INC gives a+1 and DEC gives a-1. Both write only Z, N, V and S (mask 0x1E).
- R7: AND, OR and XOR combine a and b bitwise. CLRB gives a AND NOT b. All four force V to 0 and write only Z, N, V and S (mask 0x1E).
- R8: COM gives 0xFF-a. It sets C to 1 and V to 0, and writes Z, C, N, V and S (mask 0x1F).
- R9: SHL gives a shifted left with 0 into bit 0. RLC gives the same shift with c_i into bit 0. Both put old bit 7 into C and write all six flags, as for the sum a+a(+c_i).
- R10: SHR fills bit 7 with 0. RRC fills bit 7 with c_i. SAR keeps bit 7. All three put old bit 0 into C, set V = N xor C, and write Z, C, N, V and S (mask 0x1F).
- R11: SWAP exchanges the two nibbles of a. SETALL gives 0xFF. Both write no flag (mask 0).
- R12: Whenever S is written, S equals N xor V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination register value) |
| b_i | input | 8 | Second operand (register or immediate) |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| res_o | output | 8 | Operation result |
| flags_o | output | 6 | New flag values {H,S,V,N,Z,C} |
| fwe_o | output | 6 | Flag write mask, same bit order |

## Verification
The assertions assume that the operand, operation and incoming flag inputs are settled, two-state values whenever the combinational checks evaluate. They also assume that an unassigned operation code may appear and must behave as a no-flag operation. The stimulus changes every input together, once per clock period, away from the sampling point. It sweeps every operand value for single-operand operations and every first operand against a set of boundary second operands (0, 1, 0x0F, 0x10, 0x7F, 0x80, 0xC3, 0xFF) for two-operand ones, under all four combinations of incoming carry and zero.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD    = 5'd0,
    OP_ADDC   = 5'd1,
    OP_SUB    = 5'd2,
    OP_SUBC   = 5'd3,
    OP_CMP    = 5'd4,
    OP_CMPC   = 5'd5,
    OP_NEG    = 5'd6,
    OP_INC    = 5'd7,
    OP_DEC    = 5'd8,
    OP_AND    = 5'd9,
    OP_OR     = 5'd10,
    OP_XOR    = 5'd11,
    OP_CLRB   = 5'd12,
    OP_COM    = 5'd13,
    OP_SHL    = 5'd14,
    OP_SHR    = 5'd15,
    OP_RLC    = 5'd16,
    OP_RRC    = 5'd17,
    OP_SAR    = 5'd18,
    OP_SWAP   = 5'd19,
    OP_SETALL = 5'd20
  } alu_op_e;

  localparam int FLAG_N = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef logic [FLAG_N-1:0] flag_t;

  localparam flag_t MASK_ALL   = 6'h3F;
  localparam flag_t MASK_ZNVS  = 6'h1E;
  localparam flag_t MASK_ZCNVS = 6'h1F;
  localparam flag_t MASK_NONE  = 6'h00;

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  input  logic         chain_i,
  input  logic         zprev_i,
  output logic [W-1:0] r_o,
  output flag_t        f_o
);
  localparam int HW = W / 2;

  logic [W-1:0] y_eff;
  logic         ci_eff;
  logic [W:0]   full;
  logic [HW:0]  low;

  always_comb begin
    y_eff  = sub_i ? ~y_i : y_i;
    ci_eff = sub_i ? ~cin_i : cin_i;
    full   = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, ci_eff};
    low    = {1'b0, x_i[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, ci_eff};
    r_o    = full[W-1:0];
    f_o        = '0;
    f_o[FC]    = full[W] ^ sub_i;
    f_o[FH]    = low[HW] ^ sub_i;
    f_o[FN]    = full[W-1];
    f_o[FV]    = (x_i[W-1] == y_eff[W-1]) && (full[W-1] != x_i[W-1]);
    f_o[FZ]    = (full[W-1:0] == '0) && (!chain_i || zprev_i);
    f_o[FS]    = f_o[FN] ^ f_o[FV];
  end

endmodule

// File: rtl/byte_alu_bitwise.sv
module byte_alu_bitwise
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] r_o,
  output flag_t        f_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  r_o = x_i & y_i;
      OP_OR:   r_o = x_i | y_i;
      OP_XOR:  r_o = x_i ^ y_i;
      OP_CLRB: r_o = x_i & ~y_i;
      OP_COM:  r_o = ~x_i;
      default: r_o = '0;
    endcase
    f_o     = '0;
    f_o[FC] = 1'b1;
    f_o[FV] = 1'b0;
    f_o[FN] = r_o[W-1];
    f_o[FZ] = (r_o == '0);
    f_o[FS] = r_o[W-1];
  end

endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] x_i,
  input  logic         cin_i,
  output logic [W-1:0] r_o,
  output flag_t        f_o
);
  localparam int HW = W / 2;

  logic fill;

  always_comb begin
    fill = 1'b0;
    r_o  = '0;
    unique case (op_i)
      OP_SHR:    fill = 1'b0;
      OP_RRC:    fill = cin_i;
      OP_SAR:    fill = x_i[W-1];
      default:   fill = 1'b0;
    endcase
    unique case (op_i)
      OP_SHR, OP_RRC, OP_SAR: r_o = {fill, x_i[W-1:1]};
      OP_SWAP:                r_o = {x_i[HW-1:0], x_i[W-1:HW]};
      OP_SETALL:              r_o = '1;
      default:                r_o = '0;
    endcase
    f_o     = '0;
    f_o[FC] = x_i[0];
    f_o[FN] = r_o[W-1];
    f_o[FV] = r_o[W-1] ^ x_i[0];
    f_o[FZ] = (r_o == '0);
    f_o[FS] = f_o[FN] ^ f_o[FV];
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  input  logic         z_i,
  output logic [W-1:0] res_o,
  output logic [5:0]   flags_o,
  output logic [5:0]   fwe_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [W-1:0] as_x, as_y, as_r, bw_r, sh_r;
  logic         as_ci, as_sub, as_chain;
  flag_t        as_f, bw_f, sh_f;

  // operand steering for the shared adder
  always_comb begin
    as_x     = a_i;
    as_y     = b_i;
    as_ci    = 1'b0;
    as_sub   = 1'b0;
    as_chain = 1'b0;
    unique case (op)
      OP_ADDC:         as_ci = c_i;
      OP_SUB, OP_CMP:  as_sub = 1'b1;
      OP_SUBC, OP_CMPC: begin
        as_sub   = 1'b1;
        as_ci    = c_i;
        as_chain = 1'b1;
      end
      OP_NEG: begin
        as_x   = '0;
        as_y   = a_i;
        as_sub = 1'b1;
      end
      OP_INC:          as_y = {{(W-1){1'b0}}, 1'b1};
      OP_DEC: begin
        as_y   = {{(W-1){1'b0}}, 1'b1};
        as_sub = 1'b1;
      end
      OP_SHL:          as_y = a_i;
      OP_RLC: begin
        as_y  = a_i;
        as_ci = c_i;
      end
      default: ;
    endcase
  end

  byte_alu_addsub #(.W(W)) u_addsub (
    .x_i(as_x), .y_i(as_y), .cin_i(as_ci), .sub_i(as_sub),
    .chain_i(as_chain), .zprev_i(z_i), .r_o(as_r), .f_o(as_f)
  );

  byte_alu_bitwise #(.W(W)) u_bitwise (
    .op_i(op), .x_i(a_i), .y_i(b_i), .r_o(bw_r), .f_o(bw_f)
  );

  byte_alu_shift #(.W(W)) u_shift (
    .op_i(op), .x_i(a_i), .cin_i(c_i), .r_o(sh_r), .f_o(sh_f)
  );

  // result, flag and mask selection
  always_comb begin
    res_o   = '0;
    flags_o = '0;
    fwe_o   = MASK_NONE;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_CMPC, OP_NEG,
      OP_SHL, OP_RLC: begin
        res_o = as_r; flags_o = as_f; fwe_o = MASK_ALL;
      end
      OP_INC, OP_DEC: begin
        res_o = as_r; flags_o = as_f; fwe_o = MASK_ZNVS;
      end
      OP_AND, OP_OR, OP_XOR, OP_CLRB: begin
        res_o = bw_r; flags_o = bw_f; fwe_o = MASK_ZNVS;
      end
      OP_COM: begin
        res_o = bw_r; flags_o = bw_f; fwe_o = MASK_ZCNVS;
      end
      OP_SHR, OP_RRC, OP_SAR: begin
        res_o = sh_r; flags_o = sh_f; fwe_o = MASK_ZCNVS;
      end
      OP_SWAP, OP_SETALL: begin
        res_o = sh_r; flags_o = '0; fwe_o = MASK_NONE;
      end
      default: ;
    endcase
  end

  // checks on the selected outputs
  always_comb begin
    if (fwe_o[FS]) begin
      AST_SIGN_RULE: assert (flags_o[FS] == (flags_o[FN] ^ flags_o[FV])); // R12
    end
    if (op == OP_INC || op == OP_DEC) begin
      AST_INCDEC_KEEP_CARRY: assert (!fwe_o[FC] && !fwe_o[FH]); // R6
    end
    if ((op == OP_SUBC || op == OP_CMPC) && !z_i) begin
      AST_ZERO_CHAIN: assert (!flags_o[FZ]); // R4
    end
    if (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_CLRB) begin
      AST_LOGIC_NO_OVF: assert (!flags_o[FV] && fwe_o[FV]); // R7
    end
    if (op == OP_COM) begin
      AST_COM_CARRY: assert (flags_o[FC] && res_o == ~a_i); // R8
    end
    if (op == OP_SWAP || op == OP_SETALL) begin
      AST_NO_FLAG_WRITE: assert (fwe_o == '0); // R11
    end
    if (op_i > 5'd20) begin
      AST_UNUSED_CODE: assert (fwe_o == '0 && res_o == '0); // R1
    end
    if (op == OP_SHR) begin
      AST_SHR_POSITIVE: assert (!flags_o[FN] && flags_o[FC] == a_i[0]); // R10
    end
  end

endmodule

// File: tb/tb_byte_alu.sv
module tb_byte_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic [4:0] op;
  logic [7:0] a, b;
  logic       c, z;
  logic [7:0] res;
  logic [5:0] flags, fwe;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int er, ef, em;

  byte_alu dut (
    .op_i(op), .a_i(a), .b_i(b), .c_i(c), .z_i(z),
    .res_o(res), .flags_o(flags), .fwe_o(fwe)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int pack(int cf, int zf, int nf, int vf, int hf);
    return cf + 2*zf + 4*nf + 8*vf + 16*(nf ^ vf) + 32*hf;
  endfunction

  function automatic int bsel(int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h0F; 3: return 8'h10;
      4: return 8'h7F; 5: return 8'h80; 6: return 8'hC3; default: return 8'hFF;
    endcase
  endfunction

  function automatic string tag(int o);
    if (o <= 1) return "R2";
    if (o <= 5) return "R3/R4";
    if (o == 6) return "R5";
    if (o <= 8) return "R6";
    if (o <= 12) return "R7";
    if (o == 13) return "R8";
    if (o == 14 || o == 16) return "R9";
    if (o == 15 || o == 17 || o == 18) return "R10";
    if (o <= 20) return "R11";
    return "R1";
  endfunction

  task automatic m_add(int x, int y, int ci);
    int s, sv;
    s  = x + y + ci;
    sv = sgn(x) + sgn(y) + ci;
    er = s % 256;
    ef = pack(s > 255, er == 0, er > 127, (sv > 127 || sv < -128),
              ((x % 16) + (y % 16) + ci) > 15);
  endtask

  task automatic m_sub(int x, int y, int ci, int chain, int zp);
    int d, dv;
    d  = x - y - ci;
    dv = sgn(x) - sgn(y) - ci;
    er = (d + 512) % 256;
    ef = pack(d < 0, (er == 0) && (chain == 0 || zp == 1), er > 127,
              (dv > 127 || dv < -128), ((x % 16) - (y % 16) - ci) < 0);
  endtask

  task automatic model(int o, int x, int y, int ci, int zp);
    int cf, nf;
    er = 0; ef = 0; em = 0;
    case (o)
      0: begin m_add(x, y, 0);  em = 'h3F; end
      1: begin m_add(x, y, ci); em = 'h3F; end
      2, 4: begin m_sub(x, y, 0, 0, zp);  em = 'h3F; end
      3, 5: begin m_sub(x, y, ci, 1, zp); em = 'h3F; end
      6: begin m_sub(0, x, 0, 0, zp); em = 'h3F; end
      7: begin m_add(x, 1, 0); em = 'h1E; end
      8: begin m_sub(x, 1, 0, 0, zp); em = 'h1E; end
      9, 10, 11, 12, 13: begin
        case (o)
          9:  er = x & y;
          10: er = x | y;
          11: er = x ^ y;
          12: er = x & (255 - y);
          default: er = 255 - x;
        endcase
        ef = pack(o == 13, er == 0, er > 127, 0, 0);
        em = (o == 13) ? 'h1F : 'h1E;
      end
      14: begin m_add(x, x, 0);  em = 'h3F; end
      16: begin m_add(x, x, ci); em = 'h3F; end
      15, 17, 18: begin
        er = x / 2;
        if (o == 17) er = er + 128 * ci;
        if (o == 18) er = er + (x & 128);
        cf = x % 2;
        nf = (er > 127) ? 1 : 0;
        ef = pack(cf, er == 0, nf, nf ^ cf, 0);
        em = 'h1F;
      end
      19: er = (x % 16) * 16 + x / 16;
      20: er = 255;
      default: ;
    endcase
  endtask

  task automatic run(int o, int x, int y, int ci, int zp);
    @(posedge clk);
    op = o[4:0]; a = x[7:0]; b = y[7:0]; c = ci[0]; z = zp[0];
    @(negedge clk);
    model(o, x, y, ci, zp);
    tests++;
    if (int'(res) != er || int'(fwe) != em || (int'(flags) & em) != (ef & em)) begin
      fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0d z=%0d: res=%02h flags=%02h fwe=%02h expected res=%02h flags=%02h fwe=%02h",
               tag(o), o, x, y, ci, zp, res, int'(flags) & em, fwe, er, ef & em, em);
    end
  endtask

  initial begin
    op = 0; a = 0; b = 0; c = 0; z = 0;
    // R2 R3 R4 R7: two-operand operations against boundary second operands
    for (int o = 0; o <= 12; o++) begin
      if (o >= 6 && o <= 8) continue;
      for (int bi = 0; bi < 8; bi++)
        for (int x = 0; x < 256; x++)
          for (int cz = 0; cz < 4; cz++)
            run(o, x, bsel(bi), cz % 2, cz / 2);
    end
    // R5 R6 R8 R9 R10 R11 R12: single-operand operations, full sweep
    for (int o = 6; o <= 20; o++) begin
      if (o >= 9 && o <= 12) continue;
      for (int x = 0; x < 256; x++)
        for (int cz = 0; cz < 4; cz++)
          run(o, x, 8'h5A, cz % 2, cz / 2);
    end
    // R1: unassigned codes
    for (int o = 21; o < 32; o++)
      for (int x = 0; x < 256; x += 51)
        run(o, x, 255 - x, 1, 1);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule